// File: doc/BRIEF.md
# Programmable Serial Bit Clock Generator

This block makes the serial bit clock for a codec-style serial port. It divides the system clock with a 12-bit reload counter. Loading a divider value of zero stops the internal generator. A direction control decides where the clock comes from. The clock is either made inside the block and driven onto the clock pin, or it comes from an outside device through that pin. When it comes from outside, it passes through a synchronizer of two flip-flops first.

The block decides when it owns the clock pin and when it drives it. It then gives the downstream frame and shift logic three signals: the selected bit clock, a one-cycle pulse on each rising edge of that clock, and a one-cycle pulse on each falling edge. The generator can run while the rest of the serial interface is off, because a non-zero divider claims the pin by itself.

Top module: `bitclk_divider`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `bclk`, `pin_out`, `rise_pulse` and `fall_pulse` are 0. The toggle counter starts from zero.
- R2: With `div_val` equal to 0, the internal clock `pin_out` is 0 from the next cycle on. In internal mode (`ext_dir`=0), `bclk` is also 0.
- R3: With a constant non-zero `div_val` D, the internal clock toggles once every D+1 system clock cycles, so its frequency is f_clk/(2·(D+1)).
- R4: Any change of `div_val` reloads the counter. The next toggle then comes exactly D+1 cycles after the cycle in which the new value was first seen. The level of the clock is kept across the change.
- R5: With `ext_dir`=1, `bclk` equals `pin_in` delayed by two system clock cycles, and `div_val` has no effect on `bclk`.
- R6: `pin_oe` is 1 exactly when `ext_dir`=0 and `div_val` is non-zero. `pin_out` always carries the internal divided clock.
- R7: `pin_own` is 1 when `if_en`=1 or `div_val` is non-zero, and 0 otherwise.
- R8: `rise_pulse` (or `fall_pulse`) is 1 for exactly the one cycle in which `bclk` is 1 (or 0) and was 0 (or 1) in the previous cycle, provided the source is active. The two pulses are never high together.
- R9: With `ext_dir`=0 and `div_val`=0, neither edge pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_val | input | 12 | Divider value; 0 turns the generator off |
| ext_dir | input | 1 | 1: clock comes from an external device on the pin; 0: clock is made internally |
| if_en | input | 1 | Serial interface enable; claims the pin |
| pin_in | input | 1 | Clock pin input level |
| bclk | output | 1 | Selected bit clock for the downstream logic |
| pin_out | output | 1 | Internal divided clock that drives the pin |
| pin_oe | output | 1 | Pin output enable |
| pin_own | output | 1 | Pin taken from the general-purpose port logic |
| rise_pulse | output | 1 | One-cycle pulse on a rising edge of `bclk` |
| fall_pulse | output | 1 | One-cycle pulse on a falling edge of `bclk` |

## Verification
The divider is run at 1, 3 and 4095. These three values tell apart the shortest half period, an ordinary one, and counter-width or wrap faults at full scale. The divider is changed in the middle of a half period, both with the clock low and with it high. This separates a true reload from a counter that keeps its old count. The divider is also taken to zero and back, which shows that the clock is forced low and that the edge pulses are suppressed. In external mode the pin is driven with irregular run lengths while the divider swings between zero and large values. This exposes a wrong synchronizer depth and any leak of the divider into the selected clock. Separate steps with only `if_en` set show the pin ownership coming from the enable alone.

// File: rtl/bitclk_divider.sv
module bitclk_divider #(
  parameter int DIV_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_val,
  input  logic             ext_dir,
  input  logic             if_en,
  input  logic             pin_in,
  output logic             bclk,
  output logic             pin_out,
  output logic             pin_oe,
  output logic             pin_own,
  output logic             rise_pulse,
  output logic             fall_pulse
);

  localparam int SYNC_TOP = SYNC_STAGES - 1;

  logic [DIV_W-1:0]       cnt;
  logic [DIV_W-1:0]       div_q;
  logic                   int_clk;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   sel_prev;

  wire gen_on = |div_val;
  wire reload = div_val != div_q;
  wire active = ext_dir | gen_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      div_q   <= '0;
      int_clk <= 1'b0;
    end else begin
      div_q <= div_val;
      if (!gen_on) begin
        cnt     <= '0;
        int_clk <= 1'b0;
      end else if (reload || cnt == '0) begin
        cnt <= div_val;
        if (!reload) int_clk <= ~int_clk;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= '0;
      sel_prev <= 1'b0;
    end else begin
      sync_q   <= {sync_q[SYNC_TOP-1:0], pin_in};
      sel_prev <= bclk;
    end
  end

  assign bclk       = ext_dir ? sync_q[SYNC_TOP] : int_clk;
  assign pin_out    = int_clk;
  assign pin_oe     = ~ext_dir & gen_on;
  assign pin_own    = if_en | gen_on;
  assign rise_pulse = active & bclk & ~sel_prev;
  assign fall_pulse = active & ~bclk & sel_prev;

  p_off_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (div_val == '0) |=> !pin_out);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_on && !reload && cnt != '0) |=> $stable(pin_out));

  p_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_on && !reload && cnt == '0) |=> (pin_out != $past(pin_out)));

  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_on && reload) |=> $stable(pin_out));

  p_own_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe |-> pin_own);

  p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_pulse && fall_pulse));

  p_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rise_pulse |-> (bclk && !sel_prev));

  p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_dir && div_val == '0 && $past(div_val == '0)) |-> !(rise_pulse || fall_pulse));

endmodule

// File: tb/bitclk_divider_tb.sv
`timescale 1ns/1ps
module bitclk_divider_tb;
  logic clk = 0, rst_n = 0;
  logic [11:0] div_val = 0;
  logic ext_dir = 0, if_en = 0, pin_in = 0;
  logic bclk, pin_out, pin_oe, pin_own, rise_pulse, fall_pulse;

  int checks = 0, errors = 0;
  bit done = 0;

  bitclk_divider u_dut (
    .clk(clk), .rst_n(rst_n), .div_val(div_val), .ext_dir(ext_dir),
    .if_en(if_en), .pin_in(pin_in), .bclk(bclk), .pin_out(pin_out),
    .pin_oe(pin_oe), .pin_own(pin_own), .rise_pulse(rise_pulse),
    .fall_pulse(fall_pulse));

  always #2.5 clk = ~clk;

  // behavioural reference
  bit m_clk, m_s1, m_s2, m_prev;
  int m_age, m_last_div;

  function automatic bit m_sel();
    return ext_dir ? m_s2 : m_clk;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_clk = 0; m_age = 0; m_last_div = 0; m_s1 = 0; m_s2 = 0; m_prev = 0;
    end else begin
      m_prev = m_sel();
      if (div_val == 0) begin
        m_clk = 0; m_age = 0;
      end else if (int'(div_val) != m_last_div) begin
        m_age = 0;
      end else begin
        m_age++;
        if (m_age == int'(div_val) + 1) begin
          m_clk = ~m_clk; m_age = 0;
        end
      end
      m_last_div = int'(div_val);
      m_s2 = m_s1; m_s1 = pin_in;
    end
  end

  task automatic cmp(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    bit sel, act;
    string tclk;
    sel = m_sel();
    act = ext_dir || div_val != 0;
    tclk = ext_dir ? "R5" : (div_val == 0 ? "R2" : "R3/R4");
    cmp(tclk, "bclk", bclk, sel);
    cmp("R3", "pin_out", pin_out, m_clk);
    cmp("R6", "pin_oe", pin_oe, !ext_dir && div_val != 0);
    cmp("R7", "pin_own", pin_own, if_en || div_val != 0);
    cmp(act ? "R8" : "R9", "rise_pulse", rise_pulse, act && sel && !m_prev);
    cmp(act ? "R8" : "R9", "fall_pulse", fall_pulse, act && !sel && m_prev);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      check_all();
    end
  endtask

  task automatic run_ext(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      check_all();
      if ((i % 7) == 0 || (i % 11) == 3 || (i % 5) == 4) pin_in = ~pin_in;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    div_val = 12'd3; pin_in = 1;
    @(posedge clk); #0.5;
    // R1: reset holds outputs low
    cmp("R1", "bclk in reset", bclk, 1'b0);
    cmp("R1", "pin_out in reset", pin_out, 1'b0);
    cmp("R1", "rise in reset", rise_pulse, 1'b0);
    cmp("R1", "fall in reset", fall_pulse, 1'b0);
    #0.5; rst_n = 1; pin_in = 0;
    @(posedge clk); #1;
    cmp("R1", "bclk after reset", bclk, 1'b0);
    check_all();
    run(60);
    div_val = 12'd1; run(20);
    // R4: change mid half-period while high and while low
    div_val = 12'd5; run(9);
    div_val = 12'd2; run(4);
    div_val = 12'd6; run(30);
    // R2, R9: disable
    div_val = 12'd0; run(12);
    if_en = 1; run(6);                       // R7 from enable alone
    if_en = 0; run(4);
    div_val = 12'd4095; run(8300);           // full-scale divider
    div_val = 12'd3; run(10);
    // R5: external clock, divider must not matter
    ext_dir = 1; div_val = 12'd7; run_ext(80);
    div_val = 12'd0; run_ext(60);
    div_val = 12'd4095; if_en = 1; run_ext(60);
    if_en = 0; div_val = 12'd0; run_ext(30);
    ext_dir = 0; div_val = 12'd2; run(30);
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule